// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between an on-chip request bus and an external asynchronous static RAM of 128K bytes. A client presents a 17-bit byte address, a direction flag and, for stores, one data byte, then raises a request. The controller drives the memory strobes for the whole access and answers with a one-cycle completion pulse. A load also returns the byte it fetched, marked by a valid strobe.

Every memory timing limit is a parameter in nanoseconds. The controller turns each limit into a whole number of system clock cycles by rounding up, with at least one cycle per limit. The memory has two selects of opposite polarity, one active low and one active high. The controller drives both from the same state, so the memory is either fully selected or fully in standby.

A store ends on the rising edge of the write strobe. The store byte is held on the bus for one more cycle after that edge. The controller keeps its data drivers off for the first cycles of the write strobe, the time the memory's own outputs may take to float.

Top module: `async_sram_port`

## Requirements
- R1: After reset and between transactions, the memory sits in standby: mem_sel_n=1, mem_sel=0, mem_wr_n=1, mem_rd_n=1, mem_dq_oe=0. The client-side ready and rvalid outputs are 0.
- R2: During a load, both selects are active, mem_rd_n=0 and mem_wr_n=1, and the controller never drives the data bus.
- R3: A load holds the memory strobes for max(ceil(70/P), ceil(50/P)) cycles, where P is CLK_PERIOD_NS. The byte on mem_dq_in in the last of these cycles appears on rdata. Ready and rvalid rise together as one-cycle pulses in the next cycle, so the latency from acceptance is that count plus one.
- R4: During a store, mem_wr_n stays low for at least ceil(50/P) consecutive cycles, and mem_addr does not change while mem_wr_n is low.
- R5: For the first ceil(30/P) cycles of mem_wr_n low, mem_dq_oe stays 0.
- R6: The store byte is driven for at least ceil(30/P) cycles before mem_wr_n rises. It stays driven and stable for one cycle after mem_wr_n rises, and the memory stores that byte.
- R7: A store completes with a one-cycle ready pulse and rvalid=0. Its latency from acceptance is HZ+WD+2, where HZ=ceil(30/P) and WD=max(ceil(30/P), ceil(50/P)-HZ, ceil(70/P)-HZ-1, 1).
- R8: mem_dq_oe is never 1 while mem_rd_n is 0.
- R9: A request is taken only while idle. The address, data and direction are latched when it is taken, so changes on the client inputs during a transaction have no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Transaction request, taken while idle |
| write | input | 1 | 1 = store, 0 = load |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Store data |
| ready | output | 1 | One-cycle completion pulse |
| rvalid | output | 1 | One-cycle pulse marking rdata on a load |
| rdata | output | 8 | Loaded byte |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The assertions check the following on every cycle:
- the two selects always agree;
- the data drivers are never on while the output enable is low;
- the address is stable while the write strobe is low;
- the float window at the start of a store is kept, with the drivers off;
- the write strobe is held low for its minimum width;
- the data is held and stable after the terminating edge;
- the completion pulses have the right shape.

Only the bench scenarios can show the rest:
- that the memory ends up holding the right byte;
- that loads return it;
- the exact latencies;
- that client input changes during a transaction are ignored.

// File: rtl/async_sram_port.sv
module async_sram_port #(
  parameter int AW            = 17,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 70,
  parameter int T_OE_NS       = 50,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 50,
  parameter int T_DW_NS       = 30,
  parameter int T_WHZ_NS      = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_wr_n,
  output logic          mem_rd_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = max2(cyc(T_RC_NS), cyc(T_OE_NS));
  localparam int HZ_CYC = cyc(T_WHZ_NS);
  localparam int WP_CYC = cyc(T_WP_NS);
  localparam int WD_CYC = max2(max2(cyc(T_DW_NS), WP_CYC - HZ_CYC),
                               max2(cyc(T_WC_NS) - HZ_CYC - 1, 1));
  localparam int CNT_W  = $clog2(max2(max2(RD_CYC, HZ_CYC), WD_CYC) + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WHZ, S_WDAT, S_WEND} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      ready   <= 1'b0;
      rvalid  <= 1'b0;
    end else begin
      ready  <= 1'b0;
      rvalid <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          addr_q  <= addr;
          wdata_q <= wdata;
          if (write) begin
            state <= S_WHZ;
            cnt   <= CNT_W'(HZ_CYC - 1);
          end else begin
            state <= S_RD;
            cnt   <= CNT_W'(RD_CYC - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rdata  <= mem_dq_in;
          ready  <= 1'b1;
          rvalid <= 1'b1;
          state  <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WHZ: if (cnt == '0) begin
          state <= S_WDAT;
          cnt   <= CNT_W'(WD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WDAT: if (cnt == '0) state <= S_WEND;
                else cnt <= cnt - 1'b1;
        S_WEND: begin
          ready <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = addr_q;
  assign mem_sel_n  = (state == S_IDLE);
  assign mem_sel    = (state != S_IDLE);
  assign mem_rd_n   = (state != S_RD);
  assign mem_wr_n   = !(state == S_WHZ || state == S_WDAT);
  assign mem_dq_oe  = (state == S_WDAT || state == S_WEND);
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/async_sram_port_chk.sv
module async_sram_port_chk #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int HZ_CYC = 3,
  parameter int WP_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rvalid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_sel_n,
  input logic          mem_sel,
  input logic          mem_wr_n,
  input logic          mem_rd_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (mem_wr_n) low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
  end

  assert_sel_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n == !mem_sel);
  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (mem_wr_n && !mem_dq_oe));
  assert_read_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (mem_sel && !mem_sel_n));
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && $past(!mem_wr_n)) |-> $stable(mem_addr));
  assert_wp_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_n && $past(!mem_wr_n)) |-> (int'(low_cnt) >= WP_CYC));
  assert_float_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && mem_dq_oe) |-> (int'(low_cnt) >= HZ_CYC));
  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_n && $past(!mem_wr_n)) |-> (mem_dq_oe && mem_sel && $stable(mem_dq_out)));
  assert_rvalid_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ready);
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

bind async_sram_port async_sram_port_chk #(
  .AW(AW), .DW(DW), .HZ_CYC(HZ_CYC), .WP_CYC(WP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rvalid(rvalid),
  .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_async_sram_port.sv
module sim_async_sram_port;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, write = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0, errors = 0;

  async_sram_port u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .write(write), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  always #(CLK_NS / 2) clk = ~clk;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int exp_rd_lat();
    return mx(cdiv(70), cdiv(50)) + 1;
  endfunction
  function automatic int hz_c();
    return cdiv(30);
  endfunction
  function automatic int exp_wr_lat();
    int wd;
    wd = mx(mx(cdiv(30), cdiv(50) - hz_c()), mx(cdiv(70) - hz_c() - 1, 1));
    return hz_c() + wd + 2;
  endfunction
  function automatic logic [7:0] seed_val(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
  endfunction

  logic [7:0] mem_m [int];
  logic [7:0] ref_m [int];

  function automatic logic [7:0] model_rd(input logic [16:0] a);
    return mem_m.exists(int'(a)) ? mem_m[int'(a)] : seed_val(a);
  endfunction
  function automatic logic [7:0] ref_rd(input logic [16:0] a);
    return ref_m.exists(int'(a)) ? ref_m[int'(a)] : seed_val(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model and store-timing monitor
  logic       prev_low = 1'b0;
  int         low_n = 0, drv_n = 0, early_drv = 0;
  logic [7:0] pend = '0;
  always @(negedge clk) begin
    if (mem_sel && !mem_sel_n && !mem_wr_n) begin
      if (mem_dq_oe) begin
        drv_n++;
        pend = mem_dq_out;
        if (low_n < hz_c()) early_drv++;
      end
      low_n++;
      prev_low = 1'b1;
    end else if (prev_low) begin
      chk(low_n >= cdiv(50), "R4 write strobe width", low_n, cdiv(50));
      chk(early_drv == 0, "R5 drive inside float window", early_drv, 0);
      chk(drv_n >= cdiv(30), "R6 data setup cycles", drv_n, cdiv(30));
      chk(mem_dq_oe && mem_dq_out == pend, "R6 data hold after strobe", int'(mem_dq_out), int'(pend));
      mem_m[int'(mem_addr)] = pend;
      prev_low = 1'b0;
      low_n = 0;
      drv_n = 0;
      early_drv = 0;
    end
    if (mem_sel && !mem_rd_n) begin
      chk(mem_wr_n && !mem_dq_oe, "R2 read strobes and bus", {mem_wr_n, mem_dq_oe}, 2);
      mem_dq_in <= model_rd(mem_addr);
    end else mem_dq_in <= 8'hEE;
  end

  task automatic standby(input string tag);
    chk(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe && !ready && !rvalid,
        tag, {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe, ready, rvalid}, 7'b1011100);
  endtask

  task automatic txn(input bit w, input logic [16:0] a, input logic [7:0] d, input bit scramble);
    int lat = 0;
    logic [7:0] exp_d;
    @(negedge clk);
    write = w;
    addr = a;
    wdata = d;
    req = 1'b1;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) req = 1'b0;
      if (scramble && lat == 2) begin
        addr = ~a;
        wdata = ~d;
        write = ~w;
        req = 1'b1;
      end
    end while (!ready && lat < 100);
    req = 1'b0;
    if (w) begin
      chk(lat == exp_wr_lat(), "R7 store latency", lat, exp_wr_lat());
      chk(!rvalid, "R7 rvalid stays low on store", rvalid, 0);
      ref_m[int'(a)] = d;
    end else begin
      exp_d = ref_rd(a);
      chk(lat == exp_rd_lat(), "R3 load latency", lat, exp_rd_lat());
      chk(rvalid && rdata == exp_d, scramble ? "R9 load ignores input changes" : "R3 load data",
          int'(rdata), int'(exp_d));
    end
    @(negedge clk);
    standby("R1 standby between transactions");
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    standby("R1 standby during reset");
    rst_n = 1'b1;
    @(negedge clk);
    standby("R1 standby after reset");
    txn(1'b0, 17'h00000, 8'h00, 1'b0);
    txn(1'b0, 17'h1FFFF, 8'h00, 1'b0);
    txn(1'b1, 17'h00000, 8'hA5, 1'b0);
    txn(1'b1, 17'h1FFFF, 8'h3C, 1'b0);
    txn(1'b0, 17'h00000, 8'h00, 1'b0);
    txn(1'b0, 17'h1FFFF, 8'h00, 1'b0);
    txn(1'b1, 17'h00123, 8'hF0, 1'b1);
    txn(1'b0, 17'h00123, 8'h00, 1'b1);
    txn(1'b0, ~17'h00123, 8'h00, 1'b0);
    for (int i = 0; i < 60; i++) begin
      logic [16:0] a;
      a = {$urandom} % 2 ? 17'($urandom) : 17'($urandom % 16);
      txn(1'($urandom), a, 8'($urandom), 1'($urandom % 4 == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule